// File: doc/BRIEF.md
# Memory Read ECC Error Logger

This block sits beside the read datapath of a DRAM controller. Once per transferred quadword, the ECC checker reports whether the data held a correctable or an uncorrectable error. The logger keeps two sticky status flags, one for correctable and one for uncorrectable errors. When the uncorrectable flag goes from clear to set, the logger also records the effective address of the transfer and the position of the failing quadword within that transfer.

A small register port holds three registers: a command register of enables, a status register whose bits software clears by writing 1, and the captured error address. Two one-cycle pulses go to the system's error reporting:
- a single-bit error sideband pulse for each reported correctable error;
- a bus error pulse for each logged uncorrectable error, when the external bus-error driver enable is high.

The command register also drives the enable for read data correction.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, all three registers read 0, and `single_err_pulse`, `bus_err_pulse` and `correct_en` are low.
- R2: Register select 0 is the command register, with bits 2:0 writable and every other bit reading 0. `correct_en` follows command bit 2.
- R3: A beat with `rd_ecc_ue` high, while command bit 0 is set, sets status bit 0 at the next clock edge. When status bit 0 was clear before that edge, register select 2 then reads {transfer start address in bits 31:3, quadword number in bits 2:1, 0 in bit 0}.
- R4: The quadword number is the beat's position in the transfer order. It is 0 on the beat marked `rd_beat_first` and counts up by one on each later beat, whatever the start address.
- R5: An error on a single-beat transfer records quadword number 00.
- R6: While status bit 0 is set, later uncorrectable errors do not change the captured address or quadword number.
- R7: Register select 1 is the status register, with bit 1 for correctable errors and bit 0 for uncorrectable errors. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new error in the same cycle as a clear leaves that flag set.
- R8: A beat with `rd_ecc_ce` high, while command bit 1 is set, sets status bit 1. It also raises `single_err_pulse` for exactly the one cycle after that edge.
- R9: With command bit 0 clear, uncorrectable errors set no flag, capture no address and pulse nothing. With command bit 1 clear, correctable errors set no flag and pulse nothing.
- R10: `bus_err_pulse` is high for one cycle after each logged uncorrectable beat, and only when `berr_drive_en` was high on that beat.
- R11: A beat with both error kinds, with both enables set, sets both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_beat_valid | input | 1 | A checked read quadword is present this cycle |
| rd_beat_first | input | 1 | This beat is the first of its transfer |
| rd_xfer_addr | input | 29 | Effective address bits 31:3 of the transfer, sampled on the first beat |
| rd_ecc_ce | input | 1 | Checker found a correctable error in this beat |
| rd_ecc_ue | input | 1 | Checker found an uncorrectable error in this beat |
| berr_drive_en | input | 1 | Bus error reporting driver enable |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 command, 1 status, 2 error address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected register |
| single_err_pulse | output | 1 | One-cycle sideband pulse per reported correctable error |
| bus_err_pulse | output | 1 | One-cycle bus error pulse per logged uncorrectable error |
| correct_en | output | 1 | Enable for single-bit correction of read data |

## Verification
The bench starts a burst at a start address in the middle of a line and places the error on a later beat. A design that numbered quadwords by the low address bits would record the wrong position. A second error while the flag is set checks that the first capture is kept. A design that overwrote the capture would show the newer address. A write of 0 to the status register, and a clear issued on the same edge as a fresh error, show whether the flag has the wrong write polarity or lets the clear win. Errors with each enable off, and with the bus driver enable low, show any leak into the flags or pulses.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int QW_BITS  = 2,
  parameter int CMD_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_beat_valid,
  input  logic        rd_beat_first,
  input  logic [28:0] rd_xfer_addr,
  input  logic        rd_ecc_ce,
  input  logic        rd_ecc_ue,
  input  logic        berr_drive_en,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        single_err_pulse,
  output logic        bus_err_pulse,
  output logic        correct_en
);
  localparam int AW = 32 - QW_BITS - 1;
  localparam logic [1:0] SEL_CMD = 2'd0, SEL_STS = 2'd1, SEL_ADR = 2'd2;

  logic [CMD_BITS-1:0] cmd_q;
  logic                flag_ue, flag_ce;
  logic [AW-1:0]       start_q, cap_addr;
  logic [QW_BITS-1:0]  pos_q, cap_qw;

  wire [AW-1:0]      cur_start = rd_beat_first ? rd_xfer_addr[AW-1:0] : start_q;
  wire [QW_BITS-1:0] cur_pos   = rd_beat_first ? '0 : pos_q;
  wire ue_hit = rd_beat_valid & rd_ecc_ue & cmd_q[0];
  wire ce_hit = rd_beat_valid & rd_ecc_ce & cmd_q[1];
  wire sts_wr = cfg_wr & (cfg_sel == SEL_STS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      flag_ue <= 1'b0;
      flag_ce <= 1'b0;
      start_q <= '0;
      pos_q <= '0;
      cap_addr <= '0;
      cap_qw <= '0;
      single_err_pulse <= 1'b0;
      bus_err_pulse <= 1'b0;
    end else begin
      if (rd_beat_valid) begin
        start_q <= cur_start;
        pos_q <= cur_pos + 1'b1;
      end
      if (cfg_wr && cfg_sel == SEL_CMD) cmd_q <= cfg_wdata[CMD_BITS-1:0];
      flag_ue <= ue_hit | (flag_ue & ~(sts_wr & cfg_wdata[0]));
      flag_ce <= ce_hit | (flag_ce & ~(sts_wr & cfg_wdata[1]));
      if (ue_hit && !flag_ue) begin
        cap_addr <= cur_start;
        cap_qw <= cur_pos;
      end
      single_err_pulse <= ce_hit;
      bus_err_pulse <= ue_hit & berr_drive_en;
    end
  end

  assign correct_en = cmd_q[2];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_CMD: cfg_rdata[CMD_BITS-1:0] = cmd_q;
      SEL_STS: cfg_rdata[1:0] = {flag_ce, flag_ue};
      SEL_ADR: cfg_rdata = {cap_addr, cap_qw, 1'b0};
      default: cfg_rdata = '0;
    endcase
  end

  a_r6_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_ue) && flag_ue) |-> ($stable(cap_addr) && $stable(cap_qw)));
  a_r8_sbe_flag: assert property (@(posedge clk) disable iff (!rst_n)
    single_err_pulse |-> flag_ce);
  a_r10_berr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_pulse |-> flag_ue);
  a_r9_ue_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ue) |-> $past(cmd_q[0]));
  a_r9_ce_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ce) |-> $past(cmd_q[1]));
  a_r10_berr_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_pulse |-> $past(berr_drive_en));
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic clk = 0, rst_n = 0;
  logic bv = 0, bf = 0, ce = 0, ue = 0, drv = 0, wr = 0;
  logic [28:0] baddr = '0;
  logic [1:0] sel = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic sbe, berr, cen;
  int checks = 0, errors = 0, cycles = 0;

  ecc_err_log u_dut (.clk(clk), .rst_n(rst_n), .rd_beat_valid(bv), .rd_beat_first(bf),
    .rd_xfer_addr(baddr), .rd_ecc_ce(ce), .rd_ecc_ue(ue), .berr_drive_en(drv),
    .cfg_wr(wr), .cfg_sel(sel), .cfg_wdata(wd), .cfg_rdata(rdata),
    .single_err_pulse(sbe), .bus_err_pulse(berr), .correct_en(cen));

  always #4 clk = ~clk;

  // behavioural reference
  logic [2:0] m_cmd; logic m_ue, m_ce, m_sbe, m_berr;
  logic [28:0] m_start; int m_pos; logic [31:0] m_adr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_ue = 0; m_ce = 0; m_sbe = 0; m_berr = 0; m_start = 0; m_pos = 0; m_adr = 0;
    end else begin
      logic ue_ev, ce_ev; int p; logic [28:0] s;
      ue_ev = bv && ue && m_cmd[0];
      ce_ev = bv && ce && m_cmd[1];
      p = bf ? 0 : m_pos;
      s = bf ? baddr : m_start;
      if (ue_ev && !m_ue) m_adr = {s, 2'(p), 1'b0};
      m_ue = ue_ev || (m_ue && !(wr && sel == 1 && wd[0]));
      m_ce = ce_ev || (m_ce && !(wr && sel == 1 && wd[1]));
      m_sbe = ce_ev;
      m_berr = ue_ev && drv;
      if (bv) begin m_pos = (p + 1) % 4; m_start = s; end
      if (wr && sel == 0) m_cmd = wd[2:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return {29'b0, m_cmd};
      2'd1: return {30'b0, m_ce, m_ue};
      2'd2: return m_adr;
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 sideband pulse", {31'b0, sbe}, {31'b0, m_sbe});
    chk("R10 bus error pulse", {31'b0, berr}, {31'b0, m_berr});
    chk("R2 correct_en", {31'b0, cen}, {31'b0, m_cmd[2]});
    chk("R3 register read model", rdata, m_read(sel));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #2; wr = 1; sel = s; wd = d;
    @(posedge clk); #2; wr = 0; wd = 0;
  endtask

  task automatic rreg(input logic [1:0] s, input logic [31:0] exp, input string tag);
    @(posedge clk); #2; sel = s;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic burst(input logic [28:0] a, input int n, input logic [3:0] uem, input logic [3:0] cem);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      bv = 1; bf = (i == 0); baddr = a; ue = uem[i]; ce = cem[i];
    end
    @(posedge clk); #2; bv = 0; bf = 0; ue = 0; ce = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {29'b0, sbe, berr, cen}, 32'b0);
    rreg(0, 0, "R1 command reset");
    rreg(1, 0, "R1 status reset");
    rreg(2, 0, "R1 address reset");
    wreg(0, 32'hFFFF_FFFF);
    rreg(0, 32'h7, "R2 command readback");
    chk("R2 correct_en high", {31'b0, cen}, 32'h1);
    wreg(0, 32'h0);
    drv = 1;
    burst(29'h0ABC_0001, 4, 4'b1111, 4'b1111);
    rreg(1, 0, "R9 no flags when disabled");
    rreg(2, 0, "R9 no capture when disabled");
    wreg(0, 32'h3);
    burst(29'h0123_4563, 4, 4'b0100, 4'b0000);
    rreg(1, 32'h1, "R3 ue flag set");
    rreg(2, {29'h0123_4563, 2'd2, 1'b0}, "R4 transfer-order quadword");
    burst(29'h0777_0000, 4, 4'b0011, 4'b0000);
    rreg(2, {29'h0123_4563, 2'd2, 1'b0}, "R6 first capture kept");
    wreg(1, 32'h0);
    rreg(1, 32'h1, "R7 write 0 keeps flag");
    wreg(1, 32'h1);
    rreg(1, 32'h0, "R7 write 1 clears flag");
    burst(29'h0055_5557, 1, 4'b0001, 4'b0000);
    rreg(2, {29'h0055_5557, 2'd0, 1'b0}, "R5 single beat quadword 00");
    wreg(1, 32'h3);
    burst(29'h0000_0011, 4, 4'b1000, 4'b1000);
    rreg(1, 32'h3, "R11 both flags");
    rreg(2, {29'h0000_0011, 2'd3, 1'b0}, "R3 capture after clear");
    // clear on the same edge as a fresh uncorrectable error
    @(posedge clk); #2; wr = 1; sel = 1; wd = 32'h3; bv = 1; bf = 1; baddr = 29'h9; ue = 1;
    @(posedge clk); #2; wr = 0; wd = 0; bv = 0; bf = 0; ue = 0;
    rreg(1, 32'h1, "R7 set wins over clear");
    drv = 0;
    wreg(1, 32'h3);
    burst(29'h0000_0200, 2, 4'b0010, 4'b0001);
    rreg(1, 32'h3, "R10 flags set with driver off");
    wreg(0, 32'h2);
    wreg(1, 32'h3);
    burst(29'h0000_0300, 2, 4'b0011, 4'b0010);
    rreg(1, 32'h2, "R9 ue ignored, R8 ce logged");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule